// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the software-visible configuration of a 95-pin general-purpose I/O controller. A plain 32-bit register bus is used to reach it. Each access gives a byte address, a write strobe, write data, and a combinational read-data return. The address space holds two kinds of register.

The first kind is a set of pin bitmaps, each spread over three 32-bit words. These are the firmware ownership map, the interrupt-controller routing map, the interrupt status and the interrupt enable. A single global control word sits beside them. The second kind is a pair of configuration words for every pin.

From the configuration words the bank drives each pad's output level, output enable, function select and weak pull. It also hands each pin's trigger-select and trigger-invert bits to the interrupt detection logic, which lives outside this block. Pad input levels are synchronised, and software can read them back through the first configuration word.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin's first configuration word reads 0x00000004 (native function, input direction), every second configuration word reads 0x00000004 (sensing disabled, no pull), the enable bitmap and the global control word read 0, and no pad output is enabled.
- R2: A pin's first configuration word is at 0x100 + 8*pin and its second at 0x104 + 8*pin; address bits 1:0 are ignored. In the first word, bit 31 (output level), bit 4 (trigger select), bit 3 (trigger invert), bit 2 (direction, 1 = input) and bits 1:0 (function select) are writable and read back. Bits 29:5 read 0.
- R3: A pad's output enable is 1 only when function select is 1 (GPIO) and the direction bit is 0. While enabled, the pad's output equals bit 31; otherwise it is 0. The function select value is also driven on the pad's use output.
- R4: In the second configuration word, bit 2 disables input sensing and bits 1:0 set the pull code (0 none, 1 down, 2 up), which is driven on the pad's pull output. Bits 31:3 read 0.
- R5: Bit 30 of the first word is read-only and writes to it are ignored. It shows the pad input after a two-flop synchroniser when sensing is enabled, and reads 0 when sensing is disabled.
- R6: A bitmap flag for a pin is bit (pin mod 32) of the word at base + 4*(pin/32). The ownership bitmap (base 0x00) and the routing bitmap (base 0x10) return their reset-time parameter values and ignore writes.
- R7: The interrupt enable bitmap (base 0x90) is writable. An enable bit whose ownership bit is 0 (firmware-reserved pin) stays 0, and the bitmap is driven on the enable output.
- R8: The interrupt status bitmap (base 0x80) reads the status input and ignores writes.
- R9: The global control word at 0x7C is a 32-bit read/write register driven on its own output.
- R10: Unmapped addresses read 0 and writes to them change nothing. Bitmap bits above pin 94 read 0.
- R11: Each pin's trigger-level and trigger-invert outputs follow bits 4 and 3 of its first configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| pad_in_i | input | 95 | Raw pad input levels |
| pad_out_o | output | 95 | Pad output levels |
| pad_oe_o | output | 95 | Pad output enables |
| pad_use_o | output | 95x2 | Per-pin function select |
| pad_pull_o | output | 95x2 | Per-pin pull code |
| trig_level_o | output | 95 | Per-pin trigger select (1 = level) |
| trig_inv_o | output | 95 | Per-pin trigger invert |
| int_status_i | input | 95 | Interrupt status from detection logic |
| int_en_o | output | 95 | Interrupt enable bitmap |
| glb_ctrl_o | output | 32 | Global control word |

## Verification
The hardest state to reach from the ports is the input-level bit. Its readback depends on the synchroniser pipeline, the sensing-disable bit of the other configuration word, and a write to the same word that tries to set the read-only bit. The stimulus therefore interleaves random pad changes with random writes to both words of random pins, and waits three cycles after every pad change before reading back.

Directed cases cover the remaining edges. They write all ones to enable words that contain firmware-reserved pins, including pin 94 in the last word. They also hit the first address past the last pin pair and check that it stays zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OWN_BASE  = 'h000;
  localparam int ROUTE_BASE = 'h010;
  localparam int GCTL_ADDR = 'h07C;
  localparam int STAT_BASE = 'h080;
  localparam int EN_BASE   = 'h090;
  localparam int CFG_BASE  = 'h100;

  localparam logic [1:0] USE_GPIO = 2'd1;

  typedef struct packed {
    logic       trig_lvl;
    logic       trig_inv;
    logic       dir_in;
    logic [1:0] use_sel;
  } cfg1_lo_t;

  typedef struct packed {
    logic       in_dis;
    logic [1:0] pull;
  } cfg2_t;
endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we1_i,
  input  logic        we2_i,
  input  logic        wd_out_i,
  input  logic [4:0]  wd_lo_i,
  input  logic        pad_in_i,
  output logic [31:0] cfg1_rd_o,
  output logic [31:0] cfg2_rd_o,
  output logic        pad_out_o,
  output logic        pad_oe_o,
  output logic [1:0]  use_o,
  output logic [1:0]  pull_o,
  output logic        trig_lvl_o,
  output logic        trig_inv_o
);
  logic              out_q;
  cfg1_lo_t          c1_q;
  cfg2_t             c2_q;
  logic [SYNC_N-1:0] sync_q;
  logic              in_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      c1_q  <= '{trig_lvl: 1'b0, trig_inv: 1'b0, dir_in: 1'b1, use_sel: 2'd0};
      c2_q  <= '{in_dis: 1'b1, pull: 2'd0};
    end else begin
      if (we1_i) begin
        out_q <= wd_out_i;
        c1_q  <= cfg1_lo_t'(wd_lo_i);
      end
      if (we2_i) c2_q <= cfg2_t'(wd_lo_i[2:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], pad_in_i};
  end

  assign in_lvl     = sync_q[SYNC_N-1] & ~c2_q.in_dis;
  assign cfg1_rd_o  = {out_q, in_lvl, 25'd0, c1_q};
  assign cfg2_rd_o  = {29'd0, c2_q};
  assign pad_oe_o   = (c1_q.use_sel == USE_GPIO) && !c1_q.dir_in;
  assign pad_out_o  = pad_oe_o & out_q;
  assign use_o      = c1_q.use_sel;
  assign pull_o     = c2_q.pull;
  assign trig_lvl_o = c1_q.trig_lvl;
  assign trig_inv_o = c1_q.trig_inv;

  p_cfg1_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we1_i |=> (cfg1_rd_o[31] == $past(wd_out_i)) && (cfg1_rd_o[4:0] == $past(wd_lo_i)))
    else $error("cfg1 write lost");

  p_cfg2_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we2_i |=> (pull_o == $past(wd_lo_i[1:0])) && (cfg2_rd_o[2] == $past(wd_lo_i[2])))
    else $error("cfg2 write lost");

  p_sense_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we2_i && wd_lo_i[2]) |=> !cfg1_rd_o[30])
    else $error("input level visible while sensing disabled");
endmodule

// File: rtl/gpio_irq_en.sv
module gpio_irq_en #(
  parameter int NW     = 3,
  parameter int WIDX_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WIDX_W-1:0]  widx_i,
  input  logic [31:0]        wdata_i,
  input  logic [NW*32-1:0]   own_i,
  output logic [NW*32-1:0]   en_o
);
  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          en_q <= '0;
      else if (we_i && widx_i == WIDX_W'(w)) en_q <= wdata_i & own_i[w*32 +: 32];
    end
    assign en_o[w*32 +: 32] = en_q;

    p_en_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && widx_i == WIDX_W'(w)) |=> (en_o[w*32 +: 32] == ($past(wdata_i) & own_i[w*32 +: 32])))
      else $error("enable word write not masked by ownership");
  end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int                   NUM_PINS   = 95,
  parameter int                   ADDR_W     = 12,
  parameter int                   SYNC_N     = 2,
  parameter logic [NUM_PINS-1:0]  OWN_INIT   = '1,
  parameter logic [NUM_PINS-1:0]  ROUTE_INIT = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_en_i,
  input  logic [31:0]              wr_data_i,
  output logic [31:0]              rd_data_o,
  input  logic [NUM_PINS-1:0]      pad_in_i,
  output logic [NUM_PINS-1:0]      pad_out_o,
  output logic [NUM_PINS-1:0]      pad_oe_o,
  output logic [NUM_PINS-1:0][1:0] pad_use_o,
  output logic [NUM_PINS-1:0][1:0] pad_pull_o,
  output logic [NUM_PINS-1:0]      trig_level_o,
  output logic [NUM_PINS-1:0]      trig_inv_o,
  input  logic [NUM_PINS-1:0]      int_status_i,
  output logic [NUM_PINS-1:0]      int_en_o,
  output logic [31:0]              glb_ctrl_o
);
  localparam int NW     = (NUM_PINS + 31) / 32;
  localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int PIN_W  = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + NUM_PINS * 8);

  logic [ADDR_W-1:0] a;
  logic              cfg_hit, own_hit, rt_hit, st_hit, en_hit, gc_hit, any_hit;
  logic [PIN_W-1:0]  cfg_idx;
  logic              cfg_sel2;
  logic [WIDX_W-1:0] own_idx, rt_idx, st_idx, en_idx;
  logic [NW*32-1:0]  own_w, rt_w, st_w, en_w;
  logic [31:0]       cfg1_rd [NUM_PINS];
  logic [31:0]       cfg2_rd [NUM_PINS];
  logic [31:0]       gctl_q;

  function automatic logic bm_hit(logic [ADDR_W-1:0] ad, int base);
    return (ad >= ADDR_W'(base)) && (ad < ADDR_W'(base + NW * 4));
  endfunction

  function automatic logic [WIDX_W-1:0] bm_idx(logic [ADDR_W-1:0] ad, int base);
    return WIDX_W'((ad - ADDR_W'(base)) >> 2);
  endfunction

  assign a        = addr_i & ~ADDR_W'(3);
  assign cfg_hit  = (a >= CFG_LO) && (a < CFG_HI);
  assign cfg_idx  = PIN_W'((a - CFG_LO) >> 3);
  assign cfg_sel2 = a[2];
  assign own_hit  = bm_hit(a, OWN_BASE);
  assign rt_hit   = bm_hit(a, ROUTE_BASE);
  assign st_hit   = bm_hit(a, STAT_BASE);
  assign en_hit   = bm_hit(a, EN_BASE);
  assign gc_hit   = (a == ADDR_W'(GCTL_ADDR));
  assign any_hit  = cfg_hit | own_hit | rt_hit | st_hit | en_hit | gc_hit;
  assign own_idx  = bm_idx(a, OWN_BASE);
  assign rt_idx   = bm_idx(a, ROUTE_BASE);
  assign st_idx   = bm_idx(a, STAT_BASE);
  assign en_idx   = bm_idx(a, EN_BASE);

  // pad bitmaps to whole words; bits above the last pin stay zero
  always_comb begin
    own_w = '0;
    rt_w  = '0;
    st_w  = '0;
    own_w[NUM_PINS-1:0] = OWN_INIT;
    rt_w[NUM_PINS-1:0]  = ROUTE_INIT;
    st_w[NUM_PINS-1:0]  = int_status_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic we1, we2;
    assign we1 = wr_en_i && cfg_hit && (cfg_idx == PIN_W'(p)) && !cfg_sel2;
    assign we2 = wr_en_i && cfg_hit && (cfg_idx == PIN_W'(p)) && cfg_sel2;

    gpio_pin_cfg #(.SYNC_N(SYNC_N)) u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we1_i      (we1),
      .we2_i      (we2),
      .wd_out_i   (wr_data_i[31]),
      .wd_lo_i    (wr_data_i[4:0]),
      .pad_in_i   (pad_in_i[p]),
      .cfg1_rd_o  (cfg1_rd[p]),
      .cfg2_rd_o  (cfg2_rd[p]),
      .pad_out_o  (pad_out_o[p]),
      .pad_oe_o   (pad_oe_o[p]),
      .use_o      (pad_use_o[p]),
      .pull_o     (pad_pull_o[p]),
      .trig_lvl_o (trig_level_o[p]),
      .trig_inv_o (trig_inv_o[p])
    );
  end

  gpio_irq_en #(.NW(NW), .WIDX_W(WIDX_W)) u_irq_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && en_hit),
    .widx_i  (en_idx),
    .wdata_i (wr_data_i),
    .own_i   (own_w),
    .en_o    (en_w)
  );

  assign int_en_o = en_w[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gctl_q <= '0;
    else if (wr_en_i && gc_hit) gctl_q <= wr_data_i;
  end
  assign glb_ctrl_o = gctl_q;

  always_comb begin
    rd_data_o = '0;
    if (cfg_hit)      rd_data_o = cfg_sel2 ? cfg2_rd[cfg_idx] : cfg1_rd[cfg_idx];
    else if (own_hit) rd_data_o = own_w[own_idx*32 +: 32];
    else if (rt_hit)  rd_data_o = rt_w[rt_idx*32 +: 32];
    else if (st_hit)  rd_data_o = st_w[st_idx*32 +: 32];
    else if (en_hit)  rd_data_o = en_w[en_idx*32 +: 32];
    else if (gc_hit)  rd_data_o = gctl_q;
  end

  p_unmapped_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_hit) |=> ($stable(pad_oe_o) && $stable(int_en_o) && $stable(glb_ctrl_o)
                               && $stable(pad_pull_o) && $stable(trig_level_o)))
    else $error("write to unmapped address changed state");

  p_gctl_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && gc_hit) |=> (glb_ctrl_o == $past(wr_data_i)))
    else $error("global control write lost");

  p_oe_gpio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cfg_hit && !cfg_sel2 && wr_data_i[1:0] != USE_GPIO) |=> !pad_oe_o[$past(cfg_idx)])
    else $error("pad driven outside GPIO mode");
endmodule

// File: tb/sim_gpio_pad_bank.sv
`timescale 1ns/1ps
module sim_gpio_pad_bank;
  localparam int NP = 95;
  localparam logic [NP-1:0] B_OWN  = ~((95'd1 << 5) | (95'd1 << 40) | (95'd1 << 94));
  localparam logic [95:0]   B_RTW  = {3{32'hA5C3_0F96}};
  localparam logic [NP-1:0] B_RT   = B_RTW[NP-1:0];

  logic             clk = 0;
  logic             rst_n = 0;
  logic [11:0]      addr = '0;
  logic             we = 0;
  logic [31:0]      wd = '0;
  logic [31:0]      rd;
  logic [NP-1:0]    pin = '0;
  logic [NP-1:0]    pout, poe, tlv, tinv, stat = '0, ien;
  logic [NP-1:0][1:0] puse, ppull;
  logic [31:0]      gctl;

  int checks = 0, fails = 0;
  logic [31:0] m1 [NP];
  logic [31:0] m2 [NP];
  logic [95:0] men;
  logic [31:0] mgc;

  always #10 clk = ~clk;

  gpio_pad_bank #(.OWN_INIT(B_OWN), .ROUTE_INIT(B_RT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .pad_in_i(pin), .pad_out_o(pout), .pad_oe_o(poe),
    .pad_use_o(puse), .pad_pull_o(ppull), .trig_level_o(tlv), .trig_inv_o(tinv),
    .int_status_i(stat), .int_en_o(ien), .glb_ctrl_o(gctl));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ad, logic [31:0] d);
    @(negedge clk); addr = 12'(ad); wd = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdw(int ad, output logic [31:0] d);
    addr = 12'(ad); #1; d = rd;
  endtask

  function automatic logic [31:0] exp_c1(int p);
    return m1[p] | (32'(pin[p] & ~m2[p][2]) << 30);
  endfunction

  function automatic logic [31:0] exp_pads(int p);
    logic oe;
    oe = (m1[p][1:0] == 2'd1) && !m1[p][2];
    return {24'd0, oe, oe & m1[p][31], m1[p][1:0], m2[p][1:0], m1[p][4], m1[p][3]};
  endfunction

  function automatic logic [31:0] act_pads(int p);
    return {24'd0, poe[p], pout[p], puse[p], ppull[p], tlv[p], tinv[p]};
  endfunction

  task automatic chk_pin(string req, int p);
    logic [31:0] d;
    rdw('h100 + p*8, d); chk({req, " cfg1"}, d, exp_c1(p));
    rdw('h104 + p*8, d); chk({req, " cfg2"}, d, m2[p]);
    chk({req, " pads"}, act_pads(p), exp_pads(p));
  endtask

  function automatic logic [95:0] pad96(logic [NP-1:0] x);
    return {1'b0, x};
  endfunction

  task automatic sync_wait();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1F2E_3D4C));
    for (int p = 0; p < NP; p++) begin m1[p] = 32'h4; m2[p] = 32'h4; end
    men = '0; mgc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_pin("R1", 0);
    chk_pin("R1", 94);
    chk("R1 oe", 32'(poe == '0), 32'd1);
    for (int w = 0; w < 3; w++) begin rdw('h90 + 4*w, d); chk("R1 en", d, 32'd0); end
    rdw('h7C, d); chk("R1 gctl", d, 32'd0);

    // R6 bitmaps, read-only
    for (int w = 0; w < 3; w++) begin
      rdw('h00 + 4*w, d); chk("R6 own", d, pad96(B_OWN)[w*32 +: 32]);
      rdw('h10 + 4*w, d); chk("R6 route", d, pad96(B_RT)[w*32 +: 32]);
    end
    wr('h04, 32'h0); rdw('h04, d); chk("R6 own ro", d, pad96(B_OWN)[63:32]);
    wr('h18, 32'hFFFF_FFFF); rdw('h18, d); chk("R6 route ro", d, pad96(B_RT)[95:64]);

    // R9 global control
    wr('h7C, 32'hDEAD_BEEF); mgc = 32'hDEAD_BEEF;
    rdw('h7C, d); chk("R9 read", d, mgc); chk("R9 out", gctl, mgc);

    // R7 enable masked by ownership, R10 bit above pin 94 zero
    for (int w = 0; w < 3; w++) begin
      wr('h90 + 4*w, 32'hFFFF_FFFF);
      men[w*32 +: 32] = pad96(B_OWN)[w*32 +: 32];
      rdw('h90 + 4*w, d); chk("R7 en word", d, men[w*32 +: 32]);
    end
    chk("R7 en pin40", 32'(ien[40]), 32'd0);
    chk("R10 en bit95", d[31], 1'b0);
    chk("R7 en out", 32'(ien == men[NP-1:0]), 32'd1);

    // R8 status input, writes ignored
    stat = {$urandom, $urandom, $urandom};
    wr('h84, 32'h0);
    for (int w = 0; w < 3; w++) begin
      rdw('h80 + 4*w, d); chk("R8 status", d, pad96(stat)[w*32 +: 32]);
    end

    // R10 unmapped addresses
    rdw('h0C, d); chk("R10 gap 0x0C", d, 32'd0);
    rdw('h20, d); chk("R10 gap 0x20", d, 32'd0);
    wr('h3F8, 32'hFFFF_FFFF);
    rdw('h3F8, d); chk("R10 past last pin", d, 32'd0);
    wr('h40, 32'hFFFF_FFFF);
    chk_pin("R10 pin94 untouched", 94);
    rdw('h7C, d); chk("R10 gctl untouched", d, mgc);

    // R2 / R3 directed: pin 7, byte offset in low address bits ignored
    wr('h100 + 7*8 + 3, 32'h8000_0001); m1[7] = 32'h8000_0001;
    chk_pin("R3 gpio out high", 7);
    wr('h100 + 7*8, 32'h8000_0000); m1[7] = 32'h8000_0000;
    chk_pin("R3 native no drive", 7);
    wr('h100 + 7*8, 32'h8000_0005); m1[7] = 32'h8000_0005;
    chk_pin("R3 gpio input no drive", 7);
    wr('h100 + 7*8, 32'hFFFF_FFFF); m1[7] = 32'h8000_001F;
    chk_pin("R2 reserved bits zero", 7);
    chk("R11 trig", {tlv[7], tinv[7]}, 2'b11);

    // R5 input level through synchroniser, R4 sensing control
    pin[3] = 1'b1;
    wr('h104 + 3*8, 32'h0000_0002); m2[3] = 32'h2;
    sync_wait();
    chk_pin("R5 sensing on", 3);
    wr('h100 + 3*8, 32'h4000_0000); m1[3] = 32'h0;
    chk_pin("R5 bit30 read-only", 3);
    wr('h104 + 3*8, 32'h0000_0005); m2[3] = 32'h5;
    chk_pin("R5 sensing off", 3);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int p, k;
      logic [31:0] v;
      p = $urandom_range(NP - 1);
      k = $urandom_range(3);
      v = $urandom;
      case (k)
        0: begin wr('h100 + p*8, v); m1[p] = v & 32'h8000_001F; chk_pin("R2 rand", p); end
        1: begin wr('h104 + p*8, v); m2[p] = v & 32'h7; sync_wait(); chk_pin("R4 rand", p); end
        2: begin
          int w;
          w = p / 32;
          wr('h90 + 4*w, v); men[w*32 +: 32] = v & pad96(B_OWN)[w*32 +: 32];
          rdw('h90 + 4*w, d); chk("R7 rand", d, men[w*32 +: 32]);
        end
        default: begin
          @(negedge clk); pin = {$urandom, $urandom, $urandom};
          sync_wait(); chk_pin("R5 rand", p);
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule